// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Rate Training

This block receives asynchronous serial frames (one start bit, 8 or 9 data bits sent least significant bit first, one stop bit) and stores each frame in a four-entry receive queue. A consumer drains the queue through a valid/ready pair. A flow-control output tells the far-end transmitter when to pause.

The bit time comes from the clock. A programmable divider is multiplied by one of four oversampling ratios. In low-frequency mode, oversampling is off and the bit time is the divider value alone. Each data bit and the stop bit are sampled once, at the centre of the bit.

On request, a training unit measures the bit time from a known character and loads the divider with the result. In standard mode the training character is 0x55. In IrDA mode it is 0x00.

Top module: `uart_rx_autobaud`

## Requirements
- R1: After reset `rd_valid`, `ovf`, `ab_busy` and `ab_done` are low and `flow_ok` is high. The divider resets to 1 and the ratio code 00 selects 16, so the first frame uses a 16-clock bit.
- R2: With `lowfreq` low, a bit lasts `div * ratio` clocks. The ratio is set by `ovs_sel`: 00 gives 16, 01 gives 8, 10 gives 6 and 11 gives 4. Data arrives least significant bit first and is sampled at mid-bit.
- R3: With `lowfreq` high, a bit lasts `div` clocks.
- R4: With `nine_bit` high, a frame carries 9 data bits, delivered on `rd_data[8:0]`. With it low, `rd_data[8]` is 0.
- R5: A stop bit sampled low sets `rd_ferr` for that entry, and the data is still stored.
- R6: A low pulse on `rxd` that has ended by the start-bit centre is not a frame, and nothing is stored.
- R7: The queue holds 4 entries and returns them in arrival order. While `rd_ready` is low, `rd_valid` and `rd_data` hold.
- R8: `flow_ok` is low while one entry or fewer is free, and high otherwise.
- R9: A frame arriving while the queue is full is dropped, and the sticky `ovf` flag is set and stays set.
- R10: In standard mode a request trains on 0x55. The span from the start-bit falling edge to the falling edge that begins bit 7 is 8 bit times. The divider becomes round(span / (8 * ratio)). The training character is not stored.
- R11: In IrDA mode a request trains on 0x00. The span runs from the start-bit falling edge to the rising edge of the stop bit, 9 bit times. The divider becomes round(span / (9 * ratio)).
- R12: `ab_req` sets `ab_busy` and clears `ab_done`. Completion of training clears `ab_busy` and sets `ab_done`. No frame is stored while training is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| ovs_sel | input | 2 | Oversampling ratio code |
| lowfreq | input | 1 | Disables oversampling |
| nine_bit | input | 1 | Selects 9 data bits per frame |
| irda | input | 1 | Selects 0x00 as the training character |
| div_wr | input | 1 | Loads `div_in` into the divider |
| div_in | input | DIV_W | Divider value |
| ab_req | input | 1 | Starts rate training |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | DATA_W | Data of the head entry |
| rd_ferr | output | 1 | Framing error of the head entry |
| flow_ok | output | 1 | Far end may transmit |
| ovf | output | 1 | Sticky overflow flag |
| ab_busy | output | 1 | Training in progress |
| ab_done | output | 1 | Training finished |

## Verification
A line edge reaches the frame logic two clocks after it is driven. The stop bit is sampled at its centre, the write into the queue is registered, and `rd_valid` rises three to four clocks after that sample. The bench therefore holds the line idle for a full bit plus six clocks after every frame before it reads the queue.

`ab_done` rises within about SPAN_W + 3 clocks of the measuring edge, which falls inside the final bit of the training character. Flags are read after the frame ends. Pops are driven on the falling clock edge, so each one takes effect at the next rising edge.

// File: rtl/uabr_pkg.sv
package uabr_pkg;
  typedef enum logic [1:0] {FR_IDLE, FR_START, FR_DATA, FR_STOP} fr_state_t;
  typedef enum logic [1:0] {TR_IDLE, TR_WAIT, TR_MEAS, TR_DIV} tr_state_t;

  // oversampling ratio selected by the two-bit code
  function automatic logic [4:0] ovs_ratio(input logic [1:0] sel);
    case (sel)
      2'b00:   ovs_ratio = 5'd16;
      2'b01:   ovs_ratio = 5'd8;
      2'b10:   ovs_ratio = 5'd6;
      default: ovs_ratio = 5'd4;
    endcase
  endfunction
endpackage

// File: rtl/uabr_sdiv.sv
module uabr_sdiv #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         valid,
  output logic [W-1:0] quo
);
  localparam int CNT_W = $clog2(W + 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     rem_q, rem_d, quo_d;
  logic             valid_d;
  logic [W:0]       rem_sh;

  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo;
    valid_d = 1'b0;
    rem_sh  = {rem_q, quo[W-1]};
    if (start) begin
      run_d = 1'b1;
      cnt_d = CNT_W'(W);
      rem_d = '0;
      quo_d = num;
    end else if (run_q) begin
      if (rem_sh >= {1'b0, den}) begin
        rem_d = W'(rem_sh - {1'b0, den});
        quo_d = {quo[W-2:0], 1'b1};
      end else begin
        rem_d = rem_sh[W-1:0];
        quo_d = {quo[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_d   = 1'b0;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo   <= '0;
      valid <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      quo   <= quo_d;
      valid <= valid_d;
    end
  end
endmodule

// File: rtl/uabr_train.sv
module uabr_train
  import uabr_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int SPAN_W = DIV_W + 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             rx_s,
  input  logic             irda,
  input  logic             lowfreq,
  input  logic [1:0]       ovs_sel,
  output logic             busy,
  output logic             done,
  output logic             ld,
  output logic [DIV_W-1:0] ld_val
);
  tr_state_t         st_q, st_d;
  logic              prev_q, done_d;
  logic [1:0]        nf_q, nf_d;
  logic [SPAN_W-1:0] span_q, span_d, den, num;
  logic [SPAN_W-1:0] quo;
  logic              dv_start, dv_valid, fall, rise;
  logic [4:0]        rat;

  assign fall = prev_q & ~rx_s;
  assign rise = ~prev_q & rx_s;
  assign rat  = lowfreq ? 5'd1 : ovs_ratio(ovs_sel);
  assign den  = SPAN_W'(rat) * SPAN_W'(irda ? 4'd9 : 4'd8);
  assign num  = span_q + (den >> 1);
  assign busy = (st_q != TR_IDLE);

  always_comb begin
    st_d     = st_q;
    nf_d     = nf_q;
    span_d   = span_q;
    done_d   = done;
    dv_start = 1'b0;
    unique case (st_q)
      TR_IDLE: if (req) begin
        st_d   = TR_WAIT;
        done_d = 1'b0;
      end
      TR_WAIT: if (fall) begin
        st_d   = TR_MEAS;
        span_d = SPAN_W'(1);
        nf_d   = '0;
      end
      TR_MEAS: begin
        span_d = span_q + 1'b1;
        if (fall) nf_d = nf_q + 1'b1;
        if ((!irda && fall && nf_q == 2'd3) || (irda && rise)) begin
          dv_start = 1'b1;
          st_d     = TR_DIV;
        end
      end
      TR_DIV: if (dv_valid) begin
        st_d   = TR_IDLE;
        done_d = 1'b1;
      end
      default: st_d = TR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TR_IDLE;
      prev_q <= 1'b1;
      nf_q   <= '0;
      span_q <= '0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      prev_q <= rx_s;
      nf_q   <= nf_d;
      span_q <= span_d;
      done   <= done_d;
    end
  end

  uabr_sdiv #(.W(SPAN_W)) u_sdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dv_start),
    .num   (num),
    .den   (den),
    .valid (dv_valid),
    .quo   (quo)
  );

  assign ld     = (st_q == TR_DIV) && dv_valid;
  assign ld_val = (quo == '0) ? DIV_W'(1) : quo[DIV_W-1:0];
endmodule

// File: rtl/uabr_frame.sv
module uabr_frame
  import uabr_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int BIT_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_s,
  input  logic              nine_bit,
  input  logic [BIT_W-1:0]  bit_len,
  input  logic [BIT_W-1:0]  half_len,
  output logic              push,
  output logic [DATA_W-1:0] pdata,
  output logic              pferr
);
  fr_state_t         st_q, st_d;
  logic [BIT_W-1:0]  cnt_q, cnt_d;
  logic [3:0]        nb_q, nb_d;
  logic [DATA_W-1:0] sh_q, sh_d, pdata_d;
  logic              prev_q, push_d, pferr_d;
  logic [3:0]        nlast;

  assign nlast = nine_bit ? 4'(DATA_W - 1) : 4'(DATA_W - 2);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q + 1'b1;
    nb_d    = nb_q;
    sh_d    = sh_q;
    push_d  = 1'b0;
    pdata_d = pdata;
    pferr_d = pferr;
    unique case (st_q)
      FR_IDLE: if (en && prev_q && !rx_s) begin
        st_d  = FR_START;
        cnt_d = BIT_W'(1);
      end
      FR_START: if (cnt_q == half_len) begin
        st_d  = rx_s ? FR_IDLE : FR_DATA;
        cnt_d = BIT_W'(1);
        nb_d  = '0;
      end
      FR_DATA: if (cnt_q == bit_len) begin
        sh_d  = {rx_s, sh_q[DATA_W-1:1]};
        cnt_d = BIT_W'(1);
        nb_d  = nb_q + 1'b1;
        if (nb_q == nlast) st_d = FR_STOP;
      end
      FR_STOP: if (cnt_q == bit_len) begin
        st_d    = FR_IDLE;
        push_d  = 1'b1;
        pferr_d = ~rx_s;
        pdata_d = nine_bit ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      nb_q   <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
      push   <= 1'b0;
      pdata  <= '0;
      pferr  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      nb_q   <= nb_d;
      sh_q   <= sh_d;
      prev_q <= rx_s;
      push   <= push_d;
      pdata  <= pdata_d;
      pferr  <= pferr_d;
    end
  end
endmodule

// File: rtl/uabr_fifo.sv
module uabr_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          valid,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_d;
  logic          full, do_wr, do_rd, ovf_d;

  assign full  = (count == CW'(DEPTH));
  assign valid = (count != '0);
  assign do_wr = push && !full;
  assign do_rd = pop && valid;
  assign dout  = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = count;
    ovf_d = ovf | (push & full);
    if (do_wr) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_wr && !do_rd) cnt_d = count + 1'b1;
    if (!do_wr && do_rd) cnt_d = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      count <= cnt_d;
      ovf   <= ovf_d;
    end
  end
endmodule

// File: rtl/uart_rx_autobaud.sv
module uart_rx_autobaud
  import uabr_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int DATA_W     = 9,
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_N     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [1:0]        ovs_sel,
  input  logic              lowfreq,
  input  logic              nine_bit,
  input  logic              irda,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              ab_req,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ferr,
  output logic              flow_ok,
  output logic              ovf,
  output logic              ab_busy,
  output logic              ab_done
);
  localparam int BIT_W  = DIV_W + 5;
  localparam int SPAN_W = DIV_W + 8;
  localparam int CW     = $clog2(FIFO_DEPTH + 1);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [SYNC_N-1:0] sync_q;
  logic              rx_s;
  logic [DIV_W-1:0]  div_q;
  logic              tr_ld;
  logic [DIV_W-1:0]  tr_val;
  logic [4:0]        rat;
  logic [BIT_W-1:0]  bit_len, half_raw, half_len;
  logic              f_push, f_ferr;
  logic [DATA_W-1:0] f_data;
  logic [CW-1:0]     fifo_cnt;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  for (genvar g = 0; g < SYNC_N; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) sync_q[0] <= 1'b1;
        else            sync_q[0] <= rxd;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) sync_q[g] <= 1'b1;
        else            sync_q[g] <= sync_q[g-1];
      end
    end
  end
  assign rx_s = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  div_q <= DIV_W'(1);
    else if (tr_ld)  div_q <= tr_val;
    else if (div_wr) div_q <= div_in;
  end

  assign rat      = ovs_ratio(ovs_sel);
  assign bit_len  = lowfreq ? BIT_W'(div_q) : BIT_W'(div_q) * BIT_W'(rat);
  assign half_raw = lowfreq ? BIT_W'(div_q >> 1) : BIT_W'(div_q) * BIT_W'(rat >> 1);
  assign half_len = (half_raw == '0) ? BIT_W'(1) : half_raw;

  uabr_train #(.DIV_W(DIV_W), .SPAN_W(SPAN_W)) u_train (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (ab_req),
    .rx_s    (rx_s),
    .irda    (irda),
    .lowfreq (lowfreq),
    .ovs_sel (ovs_sel),
    .busy    (ab_busy),
    .done    (ab_done),
    .ld      (tr_ld),
    .ld_val  (tr_val)
  );

  uabr_frame #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (~ab_busy),
    .rx_s     (rx_s),
    .nine_bit (nine_bit),
    .bit_len  (bit_len),
    .half_len (half_len),
    .push     (f_push),
    .pdata    (f_data),
    .pferr    (f_ferr)
  );

  uabr_fifo #(.W(DATA_W + 1), .DEPTH(FIFO_DEPTH), .CW(CW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (f_push),
    .din   ({f_ferr, f_data}),
    .pop   (rd_ready),
    .dout  ({rd_ferr, rd_data}),
    .valid (rd_valid),
    .count (fifo_cnt),
    .ovf   (ovf)
  );

  assign flow_ok = (fifo_cnt <= CW'(FIFO_DEPTH - 2));
endmodule

// File: rtl/uabr_chk.sv
module uabr_chk #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  parameter int CW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              flow_ok,
  input logic              ovf,
  input logic              ab_busy,
  input logic              ab_done,
  input logic [CW-1:0]     fifo_cnt
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH)); // R7
  AST_FLOW_OFF_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_ok |-> rd_valid); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R9
  AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(fifo_cnt) == CW'(DEPTH)); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ab_done) |-> !ab_busy && $fell(ab_busy)); // R12
endmodule

bind uart_rx_autobaud uabr_chk #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .flow_ok  (flow_ok),
  .ovf      (ovf),
  .ab_busy  (ab_busy),
  .ab_done  (ab_done),
  .fifo_cnt (fifo_cnt)
);

// File: tb/uart_rx_autobaud_bench.sv
module uart_rx_autobaud_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [1:0]  ovs_sel = 2'b00;
  logic        lowfreq = 1'b0, nine_bit = 1'b0, irda = 1'b0;
  logic        div_wr = 1'b0, ab_req = 1'b0, rd_ready = 1'b0;
  logic [11:0] div_in = 12'd1;
  logic        rd_valid, rd_ferr, flow_ok, ovf, ab_busy, ab_done;
  logic [8:0]  rd_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_autobaud u_uart_rx_autobaud (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .ovs_sel(ovs_sel), .lowfreq(lowfreq),
    .nine_bit(nine_bit), .irda(irda), .div_wr(div_wr), .div_in(div_in),
    .ab_req(ab_req), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ferr(rd_ferr), .flow_ok(flow_ok), .ovf(ovf), .ab_busy(ab_busy),
    .ab_done(ab_done)
  );

  function automatic int ratio_of(int sel);
    case (sel)
      0: return 16;
      1: return 8;
      2: return 6;
      default: return 4;
    endcase
  endfunction

  function automatic int bit_time(int dv, int sel, bit lf);
    return lf ? dv : dv * ratio_of(sel);
  endfunction

  // divider expected from training: round(span / (periods * ratio))
  function automatic int trained_div(int t, int sel, bit lf, bit ir);
    int per, den;
    per = ir ? 9 : 8;
    den = per * (lf ? 1 : ratio_of(sel));
    return (per * t + den / 2) / den;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(int dv, int sel, bit lf, bit nb, bit ir);
    @(negedge clk);
    div_in = 12'(dv); ovs_sel = 2'(sel); lowfreq = lf; nine_bit = nb; irda = ir;
    div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int data, int nbits, bit stopv, int t);
    @(negedge clk);
    rxd = 1'b0; idle(t);
    for (int i = 0; i < nbits; i++) begin
      rxd = data[i]; idle(t);
    end
    rxd = stopv; idle(t);
    rxd = 1'b1; idle(t + 6);
  endtask

  task automatic pop_chk(string tag, int exp_d, bit exp_f);
    @(negedge clk);
    chk(tag, int'(rd_valid), 1);
    chk(tag, int'(rd_data), exp_d);
    chk(tag, int'(rd_ferr), int'(exp_f));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic train(int t, int sel, bit ir);
    int dexp;
    cfg(1, sel, 1'b0, 1'b0, ir);
    @(negedge clk); ab_req = 1'b1;
    @(negedge clk); ab_req = 1'b0;
    chk("R12 busy after request", int'(ab_busy), 1);
    chk("R12 done cleared by request", int'(ab_done), 0);
    send(ir ? 0 : 'h55, 8, 1'b1, t);
    chk(ir ? "R11 done" : "R10 done", int'(ab_done), 1);
    chk("R12 busy cleared", int'(ab_busy), 0);
    chk("R12 training char not stored", int'(rd_valid), 0);
    dexp = trained_div(t, sel, 1'b0, ir);
    chk(ir ? "R11 divider fits rate" : "R10 divider fits rate", dexp * ratio_of(sel), t);
    send('hC3, 8, 1'b1, t);
    pop_chk(ir ? "R11 frame at trained rate" : "R10 frame at trained rate", 'hC3, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed, v [5];
    seed = $urandom(32'd7321);
    idle(3); rst_n = 1'b1; idle(4);
    chk("R1 valid", int'(rd_valid), 0);
    chk("R1 flow", int'(flow_ok), 1);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 busy", int'(ab_busy), 0);
    chk("R1 done", int'(ab_done), 0);
    send('h5A, 8, 1'b1, 16);
    pop_chk("R1 default divider 1 ratio 16", 'h5A, 1'b0);

    cfg(2, 0, 1'b0, 1'b0, 1'b0);
    send('hA5, 8, 1'b1, 32);
    pop_chk("R2 ratio16 div2", 'hA5, 1'b0);
    cfg(1, 2, 1'b0, 1'b0, 1'b0);
    send('h81, 8, 1'b1, 6);
    pop_chk("R2 ratio6 div1", 'h81, 1'b0);

    for (int k = 0; k < 20; k++) begin
      int sel, dv, d, t;
      bit lf, nb;
      sel = int'($urandom % 4);
      lf  = ($urandom % 4) == 0;
      dv  = lf ? 6 + int'($urandom % 8) : 1 + int'($urandom % 3);
      nb  = 1'($urandom % 2);
      d   = int'($urandom % (nb ? 512 : 256));
      t   = bit_time(dv, sel, lf);
      cfg(dv, sel, lf, nb, 1'b0);
      send(d, nb ? 9 : 8, 1'b1, t);
      pop_chk(lf ? "R3 random lowfreq" : (nb ? "R4 random nine-bit" : "R2 random"), d, 1'b0);
    end

    cfg(9, 0, 1'b1, 1'b1, 1'b0);
    send('h1F0, 9, 1'b1, 9);
    pop_chk("R4 nine-bit msb set, R3", 'h1F0, 1'b0);

    cfg(2, 0, 1'b0, 1'b0, 1'b0);
    send('h3C, 8, 1'b0, 32);
    pop_chk("R5 low stop bit", 'h3C, 1'b1);
    send('h3D, 8, 1'b1, 32);
    pop_chk("R5 flag cleared next frame", 'h3D, 1'b0);

    @(negedge clk); rxd = 1'b0; idle(2); rxd = 1'b1; idle(120);
    chk("R6 glitch not stored", int'(rd_valid), 0);

    for (int i = 0; i < 5; i++) v[i] = int'($urandom % 256);
    send(v[0], 8, 1'b1, 32);
    send(v[1], 8, 1'b1, 32);
    chk("R8 two free", int'(flow_ok), 1);
    send(v[2], 8, 1'b1, 32);
    chk("R8 one free", int'(flow_ok), 0);
    chk("R9 no ovf before full", int'(ovf), 0);
    send(v[3], 8, 1'b1, 32);
    send(v[4], 8, 1'b1, 32);
    chk("R9 ovf set", int'(ovf), 1);
    idle(5);
    chk("R7 head held while stalled", int'(rd_data), v[0]);
    for (int i = 0; i < 4; i++) pop_chk("R7 order", v[i], 1'b0);
    @(negedge clk);
    chk("R9 fifth frame dropped", int'(rd_valid), 0);
    chk("R9 ovf sticky", int'(ovf), 1);
    chk("R8 flow back on", int'(flow_ok), 1);

    train(48, 0, 1'b0);
    train(30, 2, 1'b1);
    train(20, 3, 1'b1);
    train(32, 1, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule